// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block turns parallel data words into a framed serial bit stream. A start request opens a burst: first a frame-sync pulse whose length in transmit clock periods is programmable, then a run of data words sent back to back on the serial data line. The number of words in the burst, the number of bits in each word, the bit order and the line level between transmissions are all set by configuration inputs. The burst parameters are captured when the start request is accepted.

All serial timing follows a one-cycle transmit clock enable (`tick`). Words arrive on a valid/ready interface. The ready signal is raised only on a tick at which the shifter needs a new word. If no word is offered at that point, the line rests at its idle level and a sticky underrun flag is set. The pending word goes out as soon as it arrives.

The block also reports a memory transfer size code derived from the word length, and it supports an open-drain output mode.

The control FSM has four states:
- `ST_IDLE`: no burst is in progress. A legal start moves it to `ST_SYNC`.
- `ST_SYNC`: the frame-sync pulse is on. The last sync tick moves it to `ST_SHIFT` if a word is offered, or to `ST_WAIT` if none is.
- `ST_SHIFT`: bits are shifted out. At the end of a word it returns to `ST_IDLE` if that was the final word. Otherwise it reloads and stays in `ST_SHIFT`, or moves to `ST_WAIT` if no word is offered.
- `ST_WAIT`: the line is held at its idle level. A tick with a word offered moves it to `ST_SHIFT`.

Top module: `fsync_tx`

## Requirements
- R1: A legal start accepted in `ST_IDLE` raises `fsync` on the next clock. `fsync` stays high for exactly `cfg_sync_len`+1 ticks, so a setting of 0 gives a one-tick pulse and 255 gives 256 ticks.
- R2: A burst carries `cfg_words`+1 words. The first data bit is presented on the tick after the last sync tick, and consecutive words follow with no idle tick between them when data is available.
- R3: Each word carries `cfg_bits`+1 bits, taken from the low bits of `in_data`. Up to 32 bits per word are supported.
- R4: A start with `cfg_bits` = 0 is ignored: `busy` stays low and `cfg_err` goes to 1. `cfg_err` stays set until the next legal start clears it.
- R5: With `cfg_msb_first` = 1, bit `cfg_bits` of the word is sent first and bit 0 last. With `cfg_msb_first` = 0, bit 0 is sent first.
- R6: Whenever no data bit is being presented (idle, during sync, and while waiting for a word), `ser_data` equals `cfg_idle_lvl`.
- R7: `xfer_size` is 2'b00 (byte) for `cfg_bits` 1..7, 2'b01 (halfword) for 8..15, 2'b10 (word) for 16..31, and 2'b11 for the illegal value 0.
- R8: With `cfg_open_drain` = 1, `ser_oe` equals `ser_data`. With `cfg_open_drain` = 0, `ser_oe` is 1.
- R9: When a word is needed and `in_valid` is low, the line holds its idle level and `underrun` is set. `underrun` stays set until the next legal start. The word is sent starting on the tick after it is accepted.
- R10: `busy` is high from the clock after a legal start until the tick that shifts out the last bit of the last word. Start requests while `busy` is high are ignored.
- R11: `in_ready` is high only on a tick at which a word is needed. Exactly `cfg_words`+1 handshakes occur per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Transmit clock enable, one cycle per bit period |
| start | input | 1 | Request to begin a burst |
| cfg_sync_len | input | LW | Frame-sync length minus one, in ticks |
| cfg_words | input | NW | Words per burst minus one |
| cfg_bits | input | BW | Bits per word minus one (0 illegal) |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_idle_lvl | input | 1 | Line level outside data bits |
| cfg_open_drain | input | 1 | Output enable follows the data value |
| in_data | input | DW | Parallel word to send |
| in_valid | input | 1 | Word on in_data is offered |
| in_ready | output | 1 | Word is accepted this cycle |
| ser_data | output | 1 | Serial data line |
| ser_oe | output | 1 | Serial data output enable |
| fsync | output | 1 | Frame-sync pulse |
| busy | output | 1 | Burst in progress |
| underrun | output | 1 | Sticky: a word was needed but not offered |
| cfg_err | output | 1 | Sticky: a start was refused for an illegal length |
| xfer_size | output | 2 | Transfer size code for the current word length |

## Verification
The assertions check, on every cycle:
- the idle-level rule during sync and idle;
- the open-drain and push-pull output enables;
- that `fsync`, `in_ready` and the data phase are confined to a busy burst;
- the one-clock responses to legal and illegal start requests;
- the stickiness of `underrun`.

Only the bench scenarios can show the exact pulse length in ticks, the number of words and bits, the bit order, and the placement of a late word after an underrun. These properties depend on a whole burst's worth of ticks, so the bench rebuilds the expected tick-by-tick sequence of sync and data values and compares it with the captured one.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_WAIT  = 2'd3
    } fstx_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } fstx_size_e;
endpackage

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
    import fstx_pkg::*;
#(
    parameter int LW = 8,
    parameter int NW = 4,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [LW-1:0] cfg_sync_len,
    input  logic [NW-1:0] cfg_words,
    input  logic [BW-1:0] cfg_bits,
    input  logic          cfg_msb_first,
    input  logic          in_valid,
    input  logic          word_done,
    output fstx_state_e   state,
    output logic          need_word,
    output logic          load,
    output logic          shift_en,
    output logic [BW-1:0] bits_lat,
    output logic          msb_lat,
    output logic          underrun,
    output logic          cfg_err
);
    fstx_state_e   nxt;
    logic [LW-1:0] sync_cnt;
    logic [NW-1:0] words_left;
    logic          sync_zero;
    logic          last_word;
    logic          legal_start;

    assign sync_zero   = (sync_cnt == '0);
    assign last_word   = (words_left == '0);
    assign legal_start = start && (cfg_bits != '0);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (legal_start) nxt = ST_SYNC;
            ST_SYNC:  if (tick && sync_zero) nxt = in_valid ? ST_SHIFT : ST_WAIT;
            ST_SHIFT: if (tick && word_done)
                          nxt = last_word ? ST_IDLE : (in_valid ? ST_SHIFT : ST_WAIT);
            ST_WAIT:  if (tick && in_valid) nxt = ST_SHIFT;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        need_word = 1'b0;
        shift_en  = 1'b0;
        unique case (state)
            ST_IDLE:  need_word = 1'b0;
            ST_SYNC:  need_word = tick && sync_zero;
            ST_SHIFT: begin
                need_word = tick && word_done && !last_word;
                shift_en  = tick && !word_done;
            end
            ST_WAIT:  need_word = tick;
            default:  need_word = 1'b0;
        endcase
        load = need_word && in_valid;
    end

    // burst counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt   <= '0;
            words_left <= '0;
            bits_lat   <= '0;
            msb_lat    <= 1'b0;
            underrun   <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                if (legal_start) begin
                    sync_cnt   <= cfg_sync_len;
                    words_left <= cfg_words;
                    bits_lat   <= cfg_bits;
                    msb_lat    <= cfg_msb_first;
                    underrun   <= 1'b0;
                    cfg_err    <= 1'b0;
                end else begin
                    cfg_err    <= 1'b1;
                end
            end
            if (state == ST_SYNC && tick && !sync_zero)
                sync_cnt <= sync_cnt - 1'b1;
            if (state == ST_SHIFT && tick && word_done && !last_word)
                words_left <= words_left - 1'b1;
            if (need_word && !in_valid)
                underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter #(
    parameter int DW = 32,
    parameter int BW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift_en,
    input  logic [DW-1:0] data,
    input  logic [BW-1:0] bits,
    input  logic          msb_first,
    output logic          cur_bit,
    output logic          word_done
);
    logic [DW-1:0] sr;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            bcnt <= '0;
        end else if (load) begin
            sr   <= data;
            bcnt <= bits;
        end else if (shift_en) begin
            sr   <= msb_first ? (sr << 1) : (sr >> 1);
            bcnt <= bcnt - 1'b1;
        end
    end

    assign cur_bit   = msb_first ? sr[bits] : sr[0];
    assign word_done = (bcnt == '0);
endmodule

// File: rtl/fstx_size.sv
module fstx_size
    import fstx_pkg::*;
#(
    parameter int BW = 5
) (
    input  logic [BW-1:0] bits,
    output logic [1:0]    size
);
    fstx_size_e sz;
    always_comb begin
        if (bits == '0)            sz = SZ_NONE;
        else if (int'(bits) < 8)   sz = SZ_BYTE;
        else if (int'(bits) < 16)  sz = SZ_HALF;
        else                       sz = SZ_WORD;
    end
    assign size = sz;
endmodule

// File: rtl/fsync_tx.sv
module fsync_tx
    import fstx_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 4,
    parameter int LW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [LW-1:0] cfg_sync_len,
    input  logic [NW-1:0] cfg_words,
    input  logic [BW-1:0] cfg_bits,
    input  logic          cfg_msb_first,
    input  logic          cfg_idle_lvl,
    input  logic          cfg_open_drain,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          ser_data,
    output logic          ser_oe,
    output logic          fsync,
    output logic          busy,
    output logic          underrun,
    output logic          cfg_err,
    output logic [1:0]    xfer_size
);
    fstx_state_e   state;
    logic          need_word, load, shift_en, msb_lat, cur_bit, word_done;
    logic [BW-1:0] bits_lat;

    fstx_ctrl #(.LW(LW), .NW(NW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .cfg_sync_len(cfg_sync_len), .cfg_words(cfg_words),
        .cfg_bits(cfg_bits), .cfg_msb_first(cfg_msb_first),
        .in_valid(in_valid), .word_done(word_done), .state(state),
        .need_word(need_word), .load(load), .shift_en(shift_en),
        .bits_lat(bits_lat), .msb_lat(msb_lat),
        .underrun(underrun), .cfg_err(cfg_err)
    );

    fstx_shifter #(.DW(DW), .BW(BW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .data(in_data), .bits(bits_lat), .msb_first(msb_lat),
        .cur_bit(cur_bit), .word_done(word_done)
    );

    fstx_size #(.BW(BW)) u_size (.bits(cfg_bits), .size(xfer_size));

    assign in_ready = need_word;
    assign fsync    = (state == ST_SYNC);
    assign busy     = (state != ST_IDLE);
    assign ser_data = (state == ST_SHIFT) ? cur_bit : cfg_idle_lvl;
    assign ser_oe   = cfg_open_drain ? ser_data : 1'b1;
endmodule

// File: rtl/fsync_tx_chk.sv
module fsync_tx_chk #(
    parameter int BW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          start,
    input logic [BW-1:0] cfg_bits,
    input logic          cfg_idle_lvl,
    input logic          cfg_open_drain,
    input logic          in_ready,
    input logic          ser_data,
    input logic          ser_oe,
    input logic          fsync,
    input logic          busy,
    input logic          underrun,
    input logic          cfg_err
);
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ser_data == cfg_idle_lvl); // R6
    AST_SYNC_LINE: assert property (@(posedge clk) disable iff (!rst_n) fsync |-> ser_data == cfg_idle_lvl); // R6
    AST_OD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) cfg_open_drain |-> ser_oe == ser_data); // R8
    AST_PP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_open_drain |-> ser_oe); // R8
    AST_SYNC_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) fsync |-> busy); // R1
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) fsync && !tick |=> fsync); // R1
    AST_LEGAL_START: assert property (@(posedge clk) disable iff (!rst_n) start && !busy && cfg_bits != '0 |=> busy && fsync && !cfg_err); // R10
    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n) start && !busy && cfg_bits == '0 |=> !busy && cfg_err); // R4
    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> tick && busy && !fsync || tick && fsync); // R11
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underrun && !start |=> underrun); // R9
endmodule

bind fsync_tx fsync_tx_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .cfg_bits(cfg_bits), .cfg_idle_lvl(cfg_idle_lvl),
    .cfg_open_drain(cfg_open_drain), .in_ready(in_ready),
    .ser_data(ser_data), .ser_oe(ser_oe), .fsync(fsync), .busy(busy),
    .underrun(underrun), .cfg_err(cfg_err)
);

// File: tb/fsync_tx_bench.sv
module fsync_tx_bench;
    localparam int DW = 32, NW = 4, LW = 8, BW = 5;

    logic clk = 0, rst_n = 0, tick = 0, start = 0;
    logic [LW-1:0] cfg_sync_len = '0;
    logic [NW-1:0] cfg_words = '0;
    logic [BW-1:0] cfg_bits = 5'd7;
    logic cfg_msb_first = 0, cfg_idle_lvl = 0, cfg_open_drain = 0;
    logic [DW-1:0] in_data = '0;
    logic in_valid = 0;
    logic in_ready, ser_data, ser_oe, fsync, busy, underrun, cfg_err;
    logic [1:0] xfer_size;

    int checks = 0, fails = 0;
    logic [DW-1:0] words [16];

    fsync_tx #(.DW(DW), .NW(NW), .LW(LW)) u_fsync_tx (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_size(input int w);
        if (w == 0) return 2'b11;
        if (w < 8)  return 2'b00;
        if (w < 16) return 2'b01;
        return 2'b10;
    endfunction

    task automatic run_burst(input int L, input int N, input int W, input bit msb,
                             input bit idle, input bit od, input int G, input int P);
        bit exp_fs[$], exp_d[$], got_fs[$], got_d[$];
        int tcount = 0, widx = 0, ph = 0, cyc = 0, oe_bad = 0, j, nsync = 0, dbad = 0;
        for (int i = 0; i <= N; i++) words[i] = $urandom;
        for (int i = 0; i <= L; i++) begin exp_fs.push_back(1); exp_d.push_back(idle); end
        j = (G > L + 1) ? G : L + 1;
        for (int i = 0; i < j - (L + 1); i++) begin exp_fs.push_back(0); exp_d.push_back(idle); end
        for (int w = 0; w <= N; w++)
            for (int b = 0; b <= W; b++) begin
                exp_fs.push_back(0);
                exp_d.push_back(words[w][msb ? (W - b) : b]);
            end
        @(negedge clk);
        cfg_sync_len = LW'(L); cfg_words = NW'(N); cfg_bits = BW'(W);
        cfg_msb_first = msb; cfg_idle_lvl = idle; cfg_open_drain = od;
        tick = 0; in_valid = 0; start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1, "R10", "busy after start", busy, 1);
        chk(fsync == 1, "R1", "fsync after start", fsync, 1);
        while (busy && cyc < 20000) begin
            tick = (ph == P - 1);
            ph = (ph + 1) % P;
            in_valid = (widx <= N) && (tcount + 1 >= G);
            in_data = words[widx[3:0]];
            #1;
            if (tick) begin
                got_fs.push_back(fsync); got_d.push_back(ser_data);
                if (od && ser_oe != ser_data) oe_bad++;
                tcount++;
            end
            if (in_valid && in_ready) widx++;
            @(negedge clk);
            cyc++;
        end
        tick = 0; in_valid = 0;
        #1;
        foreach (got_fs[i]) if (got_fs[i]) nsync++;
        chk(nsync == L + 1, "R1", "sync ticks", nsync, L + 1);
        chk(got_d.size() == exp_d.size(), "R2", "ticks in burst", got_d.size(), exp_d.size());
        for (int i = 0; i < exp_d.size() && i < got_d.size(); i++)
            if (got_d[i] != exp_d[i] || got_fs[i] != exp_fs[i]) dbad++;
        chk(dbad == 0, "R3/R5", "mismatched stream ticks", dbad, 0);
        chk(widx == N + 1, "R11", "handshakes", widx, N + 1);
        chk(underrun == (G > L + 1), "R9", "underrun flag", underrun, G > L + 1);
        chk(busy == 0, "R10", "busy after burst", busy, 0);
        chk(ser_data == idle, "R6", "idle line after burst", ser_data, idle);
        if (od) chk(oe_bad == 0, "R8", "open-drain enable mismatches", oe_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(busy == 0 && fsync == 0, "R10", "reset busy/fsync", {busy, fsync}, 0);
        chk(ser_data == 0 && in_ready == 0, "R6", "reset line/ready", {ser_data, in_ready}, 0);
        chk(underrun == 0 && cfg_err == 0, "R9", "reset flags", {underrun, cfg_err}, 0);
        rst_n = 1;
        @(negedge clk);
        // directed corners
        run_burst(0, 0, 7, 1, 0, 0, 0, 1);      // one-tick sync, byte MSB first
        run_burst(255, 1, 31, 0, 1, 0, 0, 1);   // 256-tick sync, 32-bit LSB first
        run_burst(3, 2, 15, 1, 0, 1, 10, 2);    // underrun at first word, open drain
        // illegal length: R4
        @(negedge clk);
        cfg_bits = '0; start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 0, "R4", "busy on illegal start", busy, 0);
        chk(cfg_err == 1, "R4", "cfg_err set", cfg_err, 1);
        run_burst(1, 0, 1, 1, 1, 0, 0, 1);      // 2-bit word, clears error
        chk(cfg_err == 0, "R4", "cfg_err cleared", cfg_err, 0);
        // size code: R7
        for (int w = 0; w < 32; w++) begin
            cfg_bits = BW'(w);
            #1;
            chk(xfer_size == exp_size(w), "R7", "xfer_size", xfer_size, exp_size(w));
        end
        // open-drain idle enable: R8
        cfg_open_drain = 1; cfg_idle_lvl = 0; #1;
        chk(ser_oe == 0, "R8", "od idle low enable", ser_oe, 0);
        cfg_idle_lvl = 1; #1;
        chk(ser_oe == 1, "R8", "od idle high enable", ser_oe, 1);
        cfg_open_drain = 0; cfg_idle_lvl = 0; #1;
        chk(ser_oe == 1, "R8", "push-pull enable", ser_oe, 1);
        // constrained random bursts
        for (int k = 0; k < 14; k++) begin
            int g;
            g = ($urandom % 3 == 0) ? int'($urandom % 30) : 0;
            run_burst(int'($urandom % 20), int'($urandom % 4), 1 + int'($urandom % 31),
                      1'($urandom), 1'($urandom), 1'($urandom), g, 1 + int'($urandom % 3));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule